// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block gathers 48 external digital inputs, brings each one into the local clock domain, and presents them as six byte-wide read-only ports on a small register bus. The bus has an 8-bit data path, a 3-bit address, a select and separate read and write strobes. There is no output direction: every pin is an input.

Every input bit is watched for a change in either direction. Edges are grouped by port, so each 8-bit port has one enable bit and one pending flag. When any bit of an enabled port toggles, that port's pending flag is latched. An active-low interrupt request is driven while any flag is pending. Software handles an interrupt as follows:
- read the status address, which returns the pending ports and a copy of the interrupt line;
- the same read clears every pending flag.

Software starts up by writing zero to the enable address and then reading the status address once.

Top module: `cos_input_port`

## Requirements
- R1: After reset the enable mask and all pending flags are zero, irq_n is 1, and every port read returns 0 until new input levels propagate.
- R2: Reads at addresses 0, 1 and 2 return input bits 7:0, 15:8 and 23:16. Reads at addresses 4, 5 and 6 return bits 31:24, 39:32 and 47:40. Each value is the level synchronized through two flops, so an input change becomes visible two clock edges after it is applied.
- R3: Reads of address 3 return 0. Bit 7 of a status read is 0. rdata is 0 in any cycle without a read.
- R4: A write to address 7 loads wdata[5:0] into the enable mask, where bit n enables port n. Writes to addresses 0 to 6 change nothing.
- R5: A rising or falling edge on any bit of an enabled port n sets pending bit n. The flag is set three clock edges after the input change. Ports whose enable bit is 0 never become pending.
- R6: irq_n is 0 exactly when some pending flag is set. A read of address 7 returns the pending flags in bits 5:0 and irq_n in bit 6.
- R7: A read of address 7 clears all pending flags. An edge detected in the same cycle as that read stays pending.
- R8: A write to address 7 clears the pending flag of each port whose new enable bit is 0.
- R9: Port reads (addresses 0 to 6) have no side effect on the pending flags or on irq_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 48 | External input pins, asynchronous |
| bus_sel | input | 1 | Register bus select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle, 0 otherwise |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check the following on every cycle:
- the read data is zero in the gaps (idle cycles and address 3);
- bit 6 of a status read matches irq_n, and bit 7 is 0;
- the enable mask changes only on writes to address 7;
- an enabled edge raises the interrupt;
- a status read with no new edge, or a write of an all-zero mask, releases the interrupt;
- a port read leaves the interrupt line unchanged.

The following can only be shown by the bench's scenarios and its per-cycle reference model:
- the port-to-address mapping;
- the two-flop latency on port reads;
- detection of both edge directions;
- an edge that lands in the same cycle as a status read staying pending.

// File: rtl/cos_input_port.sv
module cos_input_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] din,
  input  logic        bus_sel,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq_n
);
  localparam int PORTS = 6;
  localparam int BITS  = 8;
  localparam int W     = PORTS * BITS;
  localparam logic [2:0] STAT_ADDR = 3'd7;

  logic [W-1:0]     meta, lvl, lvl_d;
  logic [PORTS-1:0] enable, pend, pend_nxt, port_hit;

  wire rd_cyc  = bus_sel & bus_rd;
  wire rd_stat = rd_cyc & (bus_addr == STAT_ADDR);
  wire wr_stat = bus_sel & bus_wr & (bus_addr == STAT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= '0;
      lvl   <= '0;
      lvl_d <= '0;
    end else begin
      meta  <= din;
      lvl   <= meta;
      lvl_d <= lvl;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_hit
    assign port_hit[p] = |(lvl[p*BITS +: BITS] ^ lvl_d[p*BITS +: BITS]);
  end

  always_comb begin
    pend_nxt = rd_stat ? '0 : pend;
    pend_nxt = pend_nxt | (port_hit & enable);
    if (wr_stat) pend_nxt = pend_nxt & bus_wdata[PORTS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      pend   <= '0;
    end else begin
      pend <= pend_nxt;
      if (wr_stat) enable <= bus_wdata[PORTS-1:0];
    end
  end

  assign irq_n = ~|pend;

  always_comb begin
    bus_rdata = '0;
    if (rd_cyc) begin
      case (bus_addr)
        3'd0: bus_rdata = lvl[7:0];
        3'd1: bus_rdata = lvl[15:8];
        3'd2: bus_rdata = lvl[23:16];
        3'd4: bus_rdata = lvl[31:24];
        3'd5: bus_rdata = lvl[39:32];
        3'd6: bus_rdata = lvl[47:40];
        3'd7: bus_rdata = {1'b0, irq_n, pend};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module cos_input_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       irq_n,
  input logic [5:0] enable,
  input logic [5:0] port_hit
);
  wire rd_c   = bus_sel && bus_rd;
  wire wr_s   = bus_sel && bus_wr && bus_addr == 3'd7;
  wire rd_s   = rd_c && bus_addr == 3'd7;
  wire new_ev = |(port_hit & enable);

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_c |-> bus_rdata == 8'h00);
  assert_gap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && bus_addr == 3'd3) |-> bus_rdata == 8'h00);
  assert_status_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s |-> (bus_rdata[6] == irq_n && !bus_rdata[7]));
  assert_enable_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_s |=> $stable(enable));
  assert_enable_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s |=> enable == $past(bus_wdata[5:0]));
  assert_edge_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (new_ev && !wr_s) |=> !irq_n);
  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && !new_ev) |=> irq_n);
  assert_disable_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && bus_wdata[5:0] == 6'd0) |=> irq_n);
  assert_port_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && bus_addr != 3'd7 && !bus_wr && !new_ev) |=> $stable(irq_n));
endmodule

bind cos_input_port cos_input_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_n(irq_n), .enable(enable), .port_hit(port_hit)
);

// File: tb/cos_input_port_tb_top.sv
`timescale 1ns/1ps
module cos_input_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [47:0] din = '0;
  logic bus_sel = 0, bus_rd = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cos_input_port dut_i (.clk(clk), .rst_n(rst_n), .din(din), .bus_sel(bus_sel),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n));

  // behavioural reference: input history queue and per-port flags
  logic [47:0] hist[$];
  bit [5:0] m_en, m_pend;

  function automatic logic [47:0] seen(int age);
    return (hist.size() > age) ? hist[hist.size()-1-age] : 48'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); m_en = 0; m_pend = 0;
    end else begin
      logic [47:0] now_l, old_l;
      bit [5:0] nxt;
      now_l = seen(1); old_l = seen(2);
      nxt = (bus_sel && bus_rd && bus_addr == 7) ? 6'd0 : m_pend;
      for (int p = 0; p < 6; p++)
        if (m_en[p] && now_l[p*8 +: 8] != old_l[p*8 +: 8]) nxt[p] = 1;
      if (bus_sel && bus_wr && bus_addr == 7) begin
        m_en = bus_wdata[5:0];
        nxt = nxt & bus_wdata[5:0];
      end
      m_pend = nxt;
      hist.push_back(din);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk); #2;
    if (rst_n && !done) begin
      logic [7:0] e;
      logic [47:0] l;
      string tag;
      l = seen(1);
      e = 0; tag = "R3";
      if (bus_sel && bus_rd) begin
        case (bus_addr)
          0, 1, 2: begin e = l[bus_addr*8 +: 8]; tag = "R2"; end
          4, 5, 6: begin e = l[(bus_addr-1)*8 +: 8]; tag = "R2"; end
          7: begin e = {1'b0, ~|m_pend, m_pend}; tag = "R6"; end
          default: e = 0;
        endcase
      end
      check({tag, " model rdata"}, bus_rdata, e);
      check("R6 model irq_n", {7'd0, irq_n}, {7'd0, ~|m_pend});
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [47:0] pat;
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    check("R1 irq_n after reset", {7'd0, irq_n}, 8'd1);
    rd_reg(0, v); check("R1 port0 after reset", v, 8'h00);
    wr_reg(7, 8'h00);
    rd_reg(7, v); check("R1 status after init", v, 8'h40);
    // R2 mapping
    pat = 48'hA5C3_1E7F_0B96;
    @(negedge clk); din = pat; idle(3);
    for (int i = 0; i < 6; i++) begin
      rd_reg((i < 3) ? 3'(i) : 3'(i + 1), v);
      check($sformatf("R2 port%0d level", i), v, pat[i*8 +: 8]);
    end
    rd_reg(3, v); check("R3 address 3 reads zero", v, 8'h00);
    rd_reg(7, v); check("R5 disabled ports stay clear", v, 8'h40);
    // R4 writes to non-status addresses ignored
    wr_reg(2, 8'h3F); wr_reg(0, 8'hFF);
    @(negedge clk); din[0] = ~din[0]; idle(4);
    rd_reg(7, v); check("R4 ignored write leaves mask zero", v, 8'h40);
    // R4/R5 enable ports 0 and 2, rising edge on bit 3
    wr_reg(7, 8'h05);
    @(negedge clk); din[3] = 1'b0; idle(4);
    rd_reg(7, v);
    @(negedge clk); din[3] = 1'b1; idle(4);
    check("R6 irq asserted on pending", {7'd0, irq_n}, 8'd0);
    rd_reg(7, v); check("R5 rising edge port0", v, 8'h01);
    rd_reg(7, v); check("R7 status read cleared", v, 8'h40);
    // R5 falling edge on bit 17 (port2)
    @(negedge clk); din[17] = 1'b1; idle(4); rd_reg(7, v);
    @(negedge clk); din[17] = 1'b0; idle(4);
    rd_reg(7, v); check("R5 falling edge port2", v, 8'h04);
    // disabled port1 change
    @(negedge clk); din[9] = ~din[9]; idle(4);
    rd_reg(7, v); check("R5 disabled port1 ignored", v, 8'h40);
    // R7 edge in the same cycle as the clearing read
    @(negedge clk); din[5] = ~din[5];
    @(negedge clk);
    rd_reg(7, v); check("R7 read coincident with edge", v, 8'h40);
    rd_reg(7, v); check("R7 coincident edge kept pending", v, 8'h01);
    // R9 port reads have no side effect
    @(negedge clk); din[2] = ~din[2]; idle(4);
    rd_reg(0, v); rd_reg(4, v); rd_reg(6, v);
    check("R9 irq held across port reads", {7'd0, irq_n}, 8'd0);
    rd_reg(7, v); check("R9 pending survives port reads", v, 8'h01);
    // R8 disabling clears pending
    @(negedge clk); din[1] = ~din[1]; idle(4);
    wr_reg(7, 8'h04);
    check("R8 irq released on disable", {7'd0, irq_n}, 8'd1);
    rd_reg(7, v); check("R8 disabled port cleared", v, 8'h40);
    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) din[$urandom_range(47)] ^= 1'b1;
      bus_sel = ($urandom_range(2) != 0);
      bus_rd = $urandom_range(1);
      bus_wr = ($urandom_range(3) == 0);
      bus_addr = 3'($urandom_range(7));
      bus_wdata = 8'($urandom);
    end
    @(negedge clk); bus_sel = 0; bus_rd = 0; bus_wr = 0;
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule